// File: doc/BRIEF.md
# Sort-Then-Route Self-Routing Cell Fabric

An eight-port cell switch that moves at most one fixed-size cell per input per slot to the output named by the cell's 3-bit destination. No central controller decides the connections. A compare-exchange network sorts each slot's cells by destination, and empty inputs sort to the end. A trap stage discards every extra cell aimed at a destination already taken. A packing stage closes the gaps this leaves. The survivors then pass through a perfect shuffle and three stages of 2x2 elements. Each element reads one destination bit and steers the cell up on 0 and down on 1.

Because the cells reach the routing stages distinct, ordered and contiguous, no element ever sees two cells that want the same output. Every stage has one register, so a new slot can enter on every clock. The number of cells trapped in a slot appears on its own port in the same cycle as that slot's cells leave the fabric.

Top module: `bf_fabric`

## Requirements
- R1: While reset is held and in the first cycle after it, no output is valid and the drop count reads zero.
- R2: A slot applied on the inputs for one clock edge appears on the outputs after exactly 11 registers (6 sort, 1 trap, 1 pack, 3 routing). The cycle before that shows nothing from that slot.
- R3: Every valid input cell whose destination d (in_adr lane, 3 bits, unsigned) is unique in its slot leaves on output d with its payload unchanged.
- R4: An output is valid only if some valid input of the same slot carried that output's index as destination. Inputs with in_vld low never produce output.
- R5: When several valid cells in one slot share a destination, exactly one of them leaves on that output, with the payload of one of those cells.
- R6: out_drop equals the number of valid inputs in the slot minus the number of distinct destinations among them.
- R7: A full slot whose eight destinations form a permutation delivers all eight cells, and out_drop is zero.
- R8: Cells reaching the routing stages are sorted ascending with empties last, and no 2x2 element ever receives two cells that want the same output. This holds for any input pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 8 | Per-input cell present flag |
| in_adr | input | 8x3 | Per-input destination output index |
| in_dat | input | 8xDW | Per-input cell payload |
| out_vld | output | 8 | Per-output cell present flag |
| out_dat | output | 8xDW | Per-output cell payload |
| out_drop | output | 4 | Cells trapped as duplicates in the slot now leaving |

## Verification
The hardest case to reach from the ports is a slot that stresses the routing stages as hard as possible without blocking. Such a slot has many cells, several duplicate groups of unequal size and gaps between survivors, so that the packing and shuffle must place cells into every element pairing. The stimulus sends a directed full permutation and a slot where every cell targets one destination. It then sends random slots, and a third of them confine destinations to two values to force large duplicate groups next to empty inputs. Every slot follows the one before with no idle cycle, so any stage that mixes slots shows up at the outputs.

// File: rtl/bf_pkg.sv
package bf_pkg;

    // Number of compare-exchange columns in a bitonic sorter of 2**logn lanes.
    function automatic int sort_cols(input int logn);
        return logn * (logn + 1) / 2;
    endfunction

    // Merge block size used by sort column s for n lanes.
    function automatic int cx_blk(input int n, input int s);
        int idx;
        int res;
        idx = 0;
        res = 2;
        for (int k = 2; k <= n; k = k * 2) begin
            for (int j = k / 2; j >= 1; j = j / 2) begin
                if (idx == s) res = k;
                idx = idx + 1;
            end
        end
        return res;
    endfunction

    // Partner distance used by sort column s for n lanes.
    function automatic int cx_dist(input int n, input int s);
        int idx;
        int res;
        idx = 0;
        res = 1;
        for (int k = 2; k <= n; k = k * 2) begin
            for (int j = k / 2; j >= 1; j = j / 2) begin
                if (idx == s) res = j;
                idx = idx + 1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/bf_cmpx_stage.sv
module bf_cmpx_stage #(
    parameter int N    = 8,
    parameter int AW   = 3,
    parameter int DW   = 8,
    parameter int BLK  = 2,
    parameter int DIST = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           vld_i,
    input  logic [N-1:0][AW-1:0]   adr_i,
    input  logic [N-1:0][DW-1:0]   dat_i,
    output logic [N-1:0]           vld_o,
    output logic [N-1:0][AW-1:0]   adr_o,
    output logic [N-1:0][DW-1:0]   dat_o
);
    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][AW-1:0] adr;
        logic [N-1:0][DW-1:0] dat;
    } lane_t;

    lane_t st_d, st_q;

    // Empty lanes carry a key above every real destination.
    function automatic logic need_swap(input logic va, input logic [AW-1:0] aa,
                                       input logic vb, input logic [AW-1:0] ab,
                                       input logic up);
        logic [AW:0] ka;
        logic [AW:0] kb;
        ka = {~va, aa};
        kb = {~vb, ab};
        return up ? (ka > kb) : (ka < kb);
    endfunction

    always_comb begin
        st_d.vld = vld_i;
        st_d.adr = adr_i;
        st_d.dat = dat_i;
        for (int i = 0; i < N; i++) begin
            if ((i ^ DIST) > i) begin
                if (need_swap(vld_i[i], adr_i[i], vld_i[i ^ DIST], adr_i[i ^ DIST],
                              (i & BLK) == 0)) begin
                    st_d.vld[i]        = vld_i[i ^ DIST];
                    st_d.adr[i]        = adr_i[i ^ DIST];
                    st_d.dat[i]        = dat_i[i ^ DIST];
                    st_d.vld[i ^ DIST] = vld_i[i];
                    st_d.adr[i ^ DIST] = adr_i[i];
                    st_d.dat[i ^ DIST] = dat_i[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.vld;
    assign adr_o = st_q.adr;
    assign dat_o = st_q.dat;

endmodule

// File: rtl/bf_trap_pack.sv
module bf_trap_pack #(
    parameter int N   = 8,
    parameter int AW  = 3,
    parameter int DW  = 8,
    parameter int DCW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           vld_i,
    input  logic [N-1:0][AW-1:0]   adr_i,
    input  logic [N-1:0][DW-1:0]   dat_i,
    output logic [N-1:0]           vld_o,
    output logic [N-1:0][AW-1:0]   adr_o,
    output logic [N-1:0][DW-1:0]   dat_o,
    output logic [DCW-1:0]         drop_o
);
    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][AW-1:0] adr;
        logic [N-1:0][DW-1:0] dat;
        logic [DCW-1:0]       drop;
    } tp_t;

    tp_t trap_d, trap_q;
    tp_t pack_d, pack_q;
    logic [DCW-1:0] pos;

    // Trap: in a sorted slot duplicates sit side by side; the first survives.
    always_comb begin
        trap_d.adr    = adr_i;
        trap_d.dat    = dat_i;
        trap_d.vld[0] = vld_i[0];
        for (int i = 1; i < N; i++) begin
            trap_d.vld[i] = vld_i[i] &&
                            !(vld_i[i-1] && (adr_i[i-1] == adr_i[i]));
        end
        trap_d.drop = DCW'($countones(vld_i)) - DCW'($countones(trap_d.vld));
    end

    // Pack: survivors move to the lowest lanes, order kept.
    always_comb begin
        pack_d.vld  = '0;
        pack_d.adr  = '0;
        pack_d.dat  = '0;
        pack_d.drop = trap_q.drop;
        pos         = '0;
        for (int i = 0; i < N; i++) begin
            if (trap_q.vld[i]) begin
                pack_d.vld[pos[AW-1:0]] = 1'b1;
                pack_d.adr[pos[AW-1:0]] = trap_q.adr[i];
                pack_d.dat[pos[AW-1:0]] = trap_q.dat[i];
                pos = pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q.vld  <= '0;
            trap_q.drop <= '0;
            pack_q.vld  <= '0;
            pack_q.drop <= '0;
        end else begin
            trap_q <= trap_d;
            pack_q <= pack_d;
        end
    end

    assign vld_o  = pack_q.vld;
    assign adr_o  = pack_q.adr;
    assign dat_o  = pack_q.dat;
    assign drop_o = pack_q.drop;

    function automatic logic sorted_ok(input logic [N-1:0] v, input logic [N-1:0][AW-1:0] a);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < N - 1; i++) begin
            if (!v[i] && v[i+1]) ok = 1'b0;
            if (v[i] && v[i+1] && (a[i] > a[i+1])) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic strictly_up(input logic [N-1:0] v, input logic [N-1:0][AW-1:0] a);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < N - 1; i++) begin
            if (v[i] && v[i+1] && (a[i] >= a[i+1])) ok = 1'b0;
        end
        return ok;
    endfunction

    // R8
    sort_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sorted_ok(vld_i, adr_i));

    // R5
    pack_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pack_q.vld & (pack_q.vld + 1'b1)) == '0));

    // R5
    pack_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strictly_up(pack_q.vld, pack_q.adr));

    // R6
    drop_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'($countones(trap_q.vld)) + 32'(trap_q.drop)) == 32'($past($countones(vld_i))));

endmodule

// File: rtl/bf_omega_stage.sv
module bf_omega_stage #(
    parameter int N   = 8,
    parameter int AW  = 3,
    parameter int DW  = 8,
    parameter int BIT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           vld_i,
    input  logic [N-1:0][AW-1:0]   adr_i,
    input  logic [N-1:0][DW-1:0]   dat_i,
    output logic [N-1:0]           vld_o,
    output logic [N-1:0][AW-1:0]   adr_o,
    output logic [N-1:0][DW-1:0]   dat_o
);
    localparam int NE = N / 2;

    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][AW-1:0] adr;
        logic [N-1:0][DW-1:0] dat;
    } lane_t;

    lane_t st_d, st_q;
    logic [N-1:0]         sh_v;
    logic [N-1:0][AW-1:0] sh_a;
    logic [N-1:0][DW-1:0] sh_d;
    logic [NE-1:0]        clash;

    function automatic int rotl(input int i);
        return ((i << 1) | (i >> (AW - 1))) & (N - 1);
    endfunction

    // Perfect shuffle ahead of the element column.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            sh_v[rotl(i)] = vld_i[i];
            sh_a[rotl(i)] = adr_i[i];
            sh_d[rotl(i)] = dat_i[i];
        end
    end

    // 2x2 elements: bit 0 goes to the upper port, bit 1 to the lower.
    always_comb begin
        st_d.vld = '0;
        st_d.adr = '0;
        st_d.dat = '0;
        for (int j = 0; j < NE; j++) begin
            clash[j] = sh_v[2*j] && sh_v[2*j+1] &&
                       (sh_a[2*j][BIT] == sh_a[2*j+1][BIT]);
            if (sh_v[2*j]) begin
                st_d.vld[2*j + int'(sh_a[2*j][BIT])] = 1'b1;
                st_d.adr[2*j + int'(sh_a[2*j][BIT])] = sh_a[2*j];
                st_d.dat[2*j + int'(sh_a[2*j][BIT])] = sh_d[2*j];
            end
            if (sh_v[2*j+1] && !clash[j]) begin
                st_d.vld[2*j + int'(sh_a[2*j+1][BIT])] = 1'b1;
                st_d.adr[2*j + int'(sh_a[2*j+1][BIT])] = sh_a[2*j+1];
                st_d.dat[2*j + int'(sh_a[2*j+1][BIT])] = sh_d[2*j+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.vld;
    assign adr_o = st_q.adr;
    assign dat_o = st_q.dat;

    // R8
    elem_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash == '0);

    // R7
    cell_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.vld) == $past($countones(vld_i)));

endmodule

// File: rtl/bf_fabric.sv
module bf_fabric #(
    parameter  int N   = 8,
    parameter  int DW  = 8,
    localparam int AW  = $clog2(N),
    localparam int DCW = $clog2(N + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           in_vld,
    input  logic [N-1:0][AW-1:0]   in_adr,
    input  logic [N-1:0][DW-1:0]   in_dat,
    output logic [N-1:0]           out_vld,
    output logic [N-1:0][DW-1:0]   out_dat,
    output logic [DCW-1:0]         out_drop
);
    localparam int NSORT = bf_pkg::sort_cols(AW);

    logic [N-1:0]         s_v [NSORT+1];
    logic [N-1:0][AW-1:0] s_a [NSORT+1];
    logic [N-1:0][DW-1:0] s_d [NSORT+1];
    logic [N-1:0]         b_v [AW+1];
    logic [N-1:0][AW-1:0] b_a [AW+1];
    logic [N-1:0][DW-1:0] b_d [AW+1];
    logic [DCW-1:0]       pk_drop;

    typedef struct packed {
        logic [AW-1:0][DCW-1:0] tap;
    } dly_t;

    dly_t dl_d, dl_q;

    assign s_v[0] = in_vld;
    assign s_a[0] = in_adr;
    assign s_d[0] = in_dat;

    for (genvar s = 0; s < NSORT; s++) begin : g_sort
        bf_cmpx_stage #(
            .N(N), .AW(AW), .DW(DW),
            .BLK(bf_pkg::cx_blk(N, s)), .DIST(bf_pkg::cx_dist(N, s))
        ) u_cx (
            .clk(clk), .rst_n(rst_n),
            .vld_i(s_v[s]),   .adr_i(s_a[s]),   .dat_i(s_d[s]),
            .vld_o(s_v[s+1]), .adr_o(s_a[s+1]), .dat_o(s_d[s+1])
        );
    end

    bf_trap_pack #(.N(N), .AW(AW), .DW(DW), .DCW(DCW)) u_tp (
        .clk(clk), .rst_n(rst_n),
        .vld_i(s_v[NSORT]), .adr_i(s_a[NSORT]), .dat_i(s_d[NSORT]),
        .vld_o(b_v[0]),     .adr_o(b_a[0]),     .dat_o(b_d[0]),
        .drop_o(pk_drop)
    );

    for (genvar t = 0; t < AW; t++) begin : g_route
        bf_omega_stage #(.N(N), .AW(AW), .DW(DW), .BIT(AW - 1 - t)) u_om (
            .clk(clk), .rst_n(rst_n),
            .vld_i(b_v[t]),   .adr_i(b_a[t]),   .dat_i(b_d[t]),
            .vld_o(b_v[t+1]), .adr_o(b_a[t+1]), .dat_o(b_d[t+1])
        );
    end

    // Drop count travels beside the routing stages.
    always_comb begin
        dl_d.tap[0] = pk_drop;
        for (int t = 1; t < AW; t++) begin
            dl_d.tap[t] = dl_q.tap[t-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_q <= '0;
        end else begin
            dl_q <= dl_d;
        end
    end

    assign out_vld  = b_v[AW];
    assign out_dat  = b_d[AW];
    assign out_drop = dl_q.tap[AW-1];

    for (genvar p = 0; p < N; p++) begin : g_port_chk
        // R3
        port_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[p] |-> (b_a[AW][p] == AW'(p)));
    end

    // R6
    drop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(out_drop) + 32'($countones(out_vld))) <= N);

endmodule

// File: tb/bf_fabric_tb.sv
`timescale 1ns/1ps
module bf_fabric_tb;
    localparam int N     = 8;
    localparam int DW    = 8;
    localparam int LAT   = 11;
    localparam int NSLOT = 400;

    logic                 clk;
    logic                 rst_n;
    logic [N-1:0]         in_vld;
    logic [N-1:0][2:0]    in_adr;
    logic [N-1:0][DW-1:0] in_dat;
    logic [N-1:0]         out_vld;
    logic [N-1:0][DW-1:0] out_dat;
    logic [3:0]           out_drop;

    logic [N-1:0]  sv_vld [NSLOT];
    logic [2:0]    sv_adr [NSLOT][N];

    int n_chk;
    int n_bad;
    bit done;

    bf_fabric #(.N(N), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_adr(in_adr), .in_dat(in_dat),
        .out_vld(out_vld), .out_dat(out_dat), .out_drop(out_drop)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pay(input int s, input int i);
        return DW'((s % 32) * 8 + i);
    endfunction

    function automatic int exp_drop(input int s);
        int nv;
        int nd;
        bit seen [8];
        nv = 0;
        nd = 0;
        for (int k = 0; k < 8; k++) seen[k] = 0;
        for (int i = 0; i < N; i++) begin
            if (sv_vld[s][i]) begin
                nv++;
                if (!seen[sv_adr[s][i]]) begin
                    seen[sv_adr[s][i]] = 1;
                    nd++;
                end
            end
        end
        return nv - nd;
    endfunction

    task automatic check_slot(input int s);
        bit expv;
        bit hit;
        for (int p = 0; p < N; p++) begin
            expv = 0;
            hit  = 0;
            for (int i = 0; i < N; i++) begin
                if (sv_vld[s][i] && sv_adr[s][i] == 3'(p)) begin
                    expv = 1;
                    if (out_dat[p] == pay(s, i)) hit = 1;
                end
            end
            if (expv)
                chk(out_vld[p] == 1'b1, "R3 cell missing at its output", int'(out_vld[p]), 1);
            else
                chk(out_vld[p] == 1'b0, "R4 ghost cell on output", int'(out_vld[p]), 0);
            if (expv && out_vld[p])
                chk(hit, "R5 payload not from a cell for this output", int'(out_dat[p]), -1);
        end
        chk(int'(out_drop) == exp_drop(s), "R6 drop count", int'(out_drop), exp_drop(s));
        if (s == 2 || s == 4) begin
            // R7 full permutation: all delivered, nothing trapped
            chk(out_vld == '1 && out_drop == 0, "R7 permutation loss",
                $countones(out_vld), N);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog expired actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        n_chk = 0;
        n_bad = 0;
        done  = 0;
        void'($urandom(32'd20240517));

        // Slot table: directed corners first, then random mixes.
        for (int s = 0; s < NSLOT; s++) begin
            sv_vld[s] = '0;
            for (int i = 0; i < N; i++) sv_adr[s][i] = '0;
        end
        // slot 0: empty, 2, 2, empty, 3, empty, empty, empty
        sv_vld[0] = 8'b0001_0110;
        sv_adr[0][1] = 3'd2; sv_adr[0][2] = 3'd2; sv_adr[0][4] = 3'd3;
        // slot 1: all empty
        // slot 2: reversed permutation
        sv_vld[2] = '1;
        for (int i = 0; i < N; i++) sv_adr[2][i] = 3'(7 - i);
        // slot 3: every cell to output 5
        sv_vld[3] = '1;
        for (int i = 0; i < N; i++) sv_adr[3][i] = 3'd5;
        // slot 4: scrambled permutation
        sv_vld[4] = '1;
        for (int i = 0; i < N; i++) sv_adr[4][i] = 3'((i * 3 + 1) % 8);
        // slot 5: single cell to output 0 on the last input
        sv_vld[5] = 8'b1000_0000;
        for (int s = 6; s < NSLOT; s++) begin
            int mode;
            mode = int'($urandom % 3);
            for (int i = 0; i < N; i++) begin
                case (mode)
                    0: begin
                        sv_vld[s][i] = ($urandom % 8) != 0;
                        sv_adr[s][i] = 3'($urandom % 8);
                    end
                    1: begin
                        sv_vld[s][i] = ($urandom % 3) == 0;
                        sv_adr[s][i] = 3'($urandom % 8);
                    end
                    default: begin
                        sv_vld[s][i] = ($urandom % 2) == 0;
                        sv_adr[s][i] = 3'(4 + $urandom % 2);
                    end
                endcase
            end
        end

        rst_n  = 1'b0;
        in_vld = '0;
        in_adr = '0;
        in_dat = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_vld == '0, "R1 outputs valid in reset", int'(out_vld), 0);
        chk(out_drop == 0, "R1 drop count in reset", int'(out_drop), 0);
        rst_n = 1'b1;

        for (int c = 0; c < NSLOT + LAT + 1; c++) begin
            @(negedge clk);
            if (c == 0) begin
                chk(out_vld == '0 && out_drop == 0, "R1 outputs after reset",
                    int'(out_vld), 0);
            end
            if (c - LAT == -1) begin
                // R2: nothing of slot 0 may arrive one cycle early
                chk(out_vld == '0, "R2 early output", int'(out_vld), 0);
            end
            if (c - LAT >= 0 && c - LAT < NSLOT) check_slot(c - LAT);
            if (c < NSLOT) begin
                in_vld = sv_vld[c];
                for (int i = 0; i < N; i++) begin
                    in_adr[i] = sv_adr[c][i];
                    in_dat[i] = pay(c, i);
                end
            end else begin
                in_vld = '0;
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule